// File: doc/BRIEF.md
# Pin-Controlled Power-Down Freeze Controller

This block sits between a device's pads and its core logic and puts the core into a low-power freeze when a dedicated power-down pin is raised. The feature is turned on by a static configuration input. While it is on and the synchronised pin is high, the pads keep driving the output values and output-enable states that the core presented at the moment of entry. An output that was high-impedance at entry therefore stays high-impedance. Core inputs are cut off from the pads and held at their last sampled values, and the core clock enable is withdrawn.

When the pin drops again, the block does not return to live signals straight away. It runs a wake-up counter whose length is derived from the reference clock frequency and a wake-up time in nanoseconds, and it keeps everything frozen until the counter reaches its terminal count. If the pin rises again during wake-up, the count is abandoned and the block goes back to the frozen state with the held values untouched. When the feature is off, the block is a plain wire: the power-down pin is passed to the core as an ordinary logic input.

Top module: `pwrdn_freeze`

## Requirements
- R1: With `cfg_pd_en` low, `pad_out` equals `core_out`, `pad_oe` equals `core_oe`, `core_in` equals `pin_in`, `core_clk_en` is 1 and `pd_state` is 0, whatever `pd_pin` does.
- R2: With `cfg_pd_en` high, once the state becomes frozen, `pad_out` holds the `core_out` value sampled at the entry clock edge, and later changes on `core_out` are ignored.
- R3: The `pad_oe` value is captured and held in the same way as `pad_out`, so a lane whose enable was 0 at entry stays 0 through power-down and wake-up.
- R4: While the state is not active, `core_in` holds the last `pin_in` value sampled in the active state, changes on `pin_in` are ignored, and `core_clk_en` is 0.
- R5: `core_pd_bit` equals `pd_pin` when `cfg_pd_en` is low and is 0 when it is high.
- R6: `pd_pin` passes through a two-flop synchroniser. After it rises, the state is still active after two clock edges and becomes frozen on the third edge.
- R7: After `pd_pin` falls, the state becomes waking on the third clock edge. It stays waking for exactly WAKE_CYC cycles and then returns to active, with the pads and `core_in` held until the return.
- R8: If `pd_pin` rises while the state is waking, the state goes back to frozen without passing through active. The held values are kept, and the next wake-up starts the count afresh.
- R9: `pd_state` encodes active as 0, frozen as 1 and waking as 2. The value 3 never appears.
- R10: WAKE_CYC equals ceil(CLK_MHZ * WAKE_NS / 1000), with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset |
| cfg_pd_en | input | 1 | Enables the power-down feature |
| pd_pin | input | 1 | Asynchronous power-down pin |
| pin_in | input | IN_W | Input values from the pads |
| core_out | input | OUT_W | Output data from the core |
| core_oe | input | OUT_W | Output enables from the core |
| core_in | output | IN_W | Inputs delivered to the core |
| core_pd_bit | output | 1 | Power-down pin as a logic input (0 when the feature is on) |
| pad_out | output | OUT_W | Output data to the pads |
| pad_oe | output | OUT_W | Output enables to the pads |
| core_clk_en | output | 1 | Core clock enable |
| pd_state | output | 2 | 0 active, 1 frozen, 2 waking |

## Verification
The bench sweeps every output, enable and input pattern of a three-lane build through a complete freeze and wake-up cycle. A design that captured values one edge late would show core data that changed after entry. A design with a wrong synchroniser depth would freeze or wake on the wrong edge. The wake-up length is checked to the exact cycle against a count worked out from the clock frequency and wake-up time, so an off-by-one terminal count shows as an early or late release. An abort during wake-up must return to frozen with the original data and then run a full fresh count. A design that released briefly, recaptured, or resumed the old count fails that check. The bench also covers the feature switched off, where pad values, the clock enable and the pin bypass must track their inputs with no freezing.

// File: rtl/pwrdn_freeze_pkg.sv
package pwrdn_freeze_pkg;

   typedef enum logic [1:0] {
      PDF_ACTIVE = 2'd0,
      PDF_FROZEN = 2'd1,
      PDF_WAKING = 2'd2
   } pdf_state_e;

   function automatic int unsigned pdf_wake_cycles(input int unsigned mhz,
                                                   input int unsigned ns);
      int unsigned c;
      c = (mhz * ns + 999) / 1000;
      return (c == 0) ? 1 : c;
   endfunction

endpackage

// File: rtl/pwrdn_freeze_sync.sv
module pwrdn_freeze_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $fatal(1, "pwrdn_freeze_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= 1'b0;
               else        chain_q[gi] <= chain_q[gi-1];
            end
         end
      end
   endgenerate

   assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pwrdn_freeze_seq.sv
module pwrdn_freeze_seq
   import pwrdn_freeze_pkg::*;
#(
   parameter int unsigned WAKE_CYC = 100,
   localparam int unsigned CNT_W = (WAKE_CYC < 2) ? 1 : $clog2(WAKE_CYC)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       feat_en,
   input  logic       pd_req,
   output pdf_state_e state_q
);
   generate
      if (WAKE_CYC < 1) begin : g_bad_wake
         $fatal(1, "pwrdn_freeze_seq: WAKE_CYC must be at least 1");
      end
   endgenerate

   localparam logic [CNT_W-1:0] TERM = CNT_W'(WAKE_CYC - 1);

   logic [CNT_W-1:0] wake_cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= PDF_ACTIVE;
         wake_cnt_q <= '0;
      end else if (!feat_en) begin
         state_q    <= PDF_ACTIVE;
         wake_cnt_q <= '0;
      end else begin
         unique case (state_q)
            PDF_ACTIVE: begin
               wake_cnt_q <= '0;
               if (pd_req) state_q <= PDF_FROZEN;
            end
            PDF_FROZEN: begin
               wake_cnt_q <= '0;
               if (!pd_req) state_q <= PDF_WAKING;
            end
            PDF_WAKING: begin
               if (pd_req) begin
                  state_q    <= PDF_FROZEN;
                  wake_cnt_q <= '0;
               end else if (wake_cnt_q == TERM) begin
                  state_q    <= PDF_ACTIVE;
                  wake_cnt_q <= '0;
               end else begin
                  wake_cnt_q <= wake_cnt_q + 1'b1;
               end
            end
            default: begin
               state_q    <= PDF_ACTIVE;
               wake_cnt_q <= '0;
            end
         endcase
      end
   end
endmodule

// File: rtl/pwrdn_freeze_hold.sv
module pwrdn_freeze_hold #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pass,
   input  logic [WIDTH-1:0] live,
   output logic [WIDTH-1:0] held_view
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $fatal(1, "pwrdn_freeze_hold: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] keep_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    keep_q <= '0;
      else if (pass) keep_q <= live;
   end

   assign held_view = pass ? live : keep_q;
endmodule

// File: rtl/pwrdn_freeze.sv
module pwrdn_freeze
   import pwrdn_freeze_pkg::*;
#(
   parameter int unsigned OUT_W       = 8,
   parameter int unsigned IN_W        = 8,
   parameter int unsigned CLK_MHZ     = 100,
   parameter int unsigned WAKE_NS     = 1000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_pd_en,
   input  logic             pd_pin,
   input  logic [IN_W-1:0]  pin_in,
   input  logic [OUT_W-1:0] core_out,
   input  logic [OUT_W-1:0] core_oe,
   output logic [IN_W-1:0]  core_in,
   output logic             core_pd_bit,
   output logic [OUT_W-1:0] pad_out,
   output logic [OUT_W-1:0] pad_oe,
   output logic             core_clk_en,
   output logic [1:0]       pd_state
);
   localparam int unsigned WAKE_CYC = pdf_wake_cycles(CLK_MHZ, WAKE_NS);

   generate
      if (CLK_MHZ < 1) begin : g_bad_clk
         $fatal(1, "pwrdn_freeze: CLK_MHZ must be at least 1");
      end
   endgenerate

   logic       pd_req;
   pdf_state_e st;
   logic       pass;

   pwrdn_freeze_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pd_pin),
      .q_sync  (pd_req)
   );

   pwrdn_freeze_seq #(.WAKE_CYC(WAKE_CYC)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .feat_en (cfg_pd_en),
      .pd_req  (pd_req),
      .state_q (st)
   );

   assign pass = (st == PDF_ACTIVE) || !cfg_pd_en;

   pwrdn_freeze_hold #(.WIDTH(OUT_W)) u_hold_out (
      .clk (clk), .rst_n (rst_n), .pass (pass),
      .live (core_out), .held_view (pad_out)
   );

   pwrdn_freeze_hold #(.WIDTH(OUT_W)) u_hold_oe (
      .clk (clk), .rst_n (rst_n), .pass (pass),
      .live (core_oe), .held_view (pad_oe)
   );

   pwrdn_freeze_hold #(.WIDTH(IN_W)) u_hold_in (
      .clk (clk), .rst_n (rst_n), .pass (pass),
      .live (pin_in), .held_view (core_in)
   );

   assign core_pd_bit = cfg_pd_en ? 1'b0 : pd_pin;
   assign core_clk_en = pass;
   assign pd_state    = st;
endmodule

// File: rtl/pwrdn_freeze_chk.sv
module pwrdn_freeze_chk #(
   parameter int unsigned OUT_W    = 8,
   parameter int unsigned IN_W     = 8,
   parameter int unsigned WAKE_CYC = 100
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_pd_en,
   input logic             pd_pin,
   input logic [IN_W-1:0]  pin_in,
   input logic [OUT_W-1:0] core_out,
   input logic [OUT_W-1:0] core_oe,
   input logic [IN_W-1:0]  core_in,
   input logic             core_pd_bit,
   input logic [OUT_W-1:0] pad_out,
   input logic [OUT_W-1:0] pad_oe,
   input logic             core_clk_en,
   input logic [1:0]       pd_state
);
   localparam logic [1:0] S_ACT = 2'd0;
   localparam logic [1:0] S_FRZ = 2'd1;
   localparam logic [1:0] S_WAK = 2'd2;

   int unsigned wake_len_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 wake_len_q <= 0;
      else if (pd_state == S_WAK) wake_len_q <= wake_len_q + 1;
      else                        wake_len_q <= 0;
   end

   assert_transparent_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_pd_en |-> (pad_out == core_out && pad_oe == core_oe && core_in == pin_in));

   assert_hold_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_pd_en && pd_state != S_ACT) |=> (!cfg_pd_en || pd_state == S_ACT || $stable(pad_out)));

   assert_hold_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_pd_en && pd_state != S_ACT) |=> (!cfg_pd_en || pd_state == S_ACT || $stable(pad_oe)));

   assert_inputs_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_pd_en && pd_state != S_ACT) |=> (!cfg_pd_en || pd_state == S_ACT || ($stable(core_in) && !core_clk_en)));

   assert_pd_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_pd_en |-> !core_pd_bit);

   assert_no_direct_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_pd_en && pd_state == S_FRZ) |=> (!cfg_pd_en || pd_state != S_ACT));

   assert_wake_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_pd_en && pd_state == S_WAK) |=> (!cfg_pd_en || pd_state != S_ACT || wake_len_q == WAKE_CYC));

   assert_legal_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pd_state != 2'd3);
endmodule

bind pwrdn_freeze pwrdn_freeze_chk #(
   .OUT_W    (OUT_W),
   .IN_W     (IN_W),
   .WAKE_CYC (WAKE_CYC)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_pd_en   (cfg_pd_en),
   .pd_pin      (pd_pin),
   .pin_in      (pin_in),
   .core_out    (core_out),
   .core_oe     (core_oe),
   .core_in     (core_in),
   .core_pd_bit (core_pd_bit),
   .pad_out     (pad_out),
   .pad_oe      (pad_oe),
   .core_clk_en (core_clk_en),
   .pd_state    (pd_state)
);

// File: tb/pwrdn_freeze_bench.sv
module pwrdn_freeze_bench;
   localparam int CLK_P   = 10;
   localparam int W       = 3;
   localparam int MHZ     = 8;
   localparam int WNS     = 1000;
   localparam int EXP_WAK = (MHZ * WNS + 999) / 1000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_pd_en = 1'b1;
   logic         pd_pin = 1'b0;
   logic [W-1:0] pin_in = '0;
   logic [W-1:0] core_out = '0;
   logic [W-1:0] core_oe = '0;
   logic [W-1:0] core_in;
   logic         core_pd_bit;
   logic [W-1:0] pad_out;
   logic [W-1:0] pad_oe;
   logic         core_clk_en;
   logic [1:0]   pd_state;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   pwrdn_freeze #(
      .OUT_W(W), .IN_W(W), .CLK_MHZ(MHZ), .WAKE_NS(WNS), .SYNC_STAGES(2)
   ) u_pwrdn_freeze (
      .clk(clk), .rst_n(rst_n), .cfg_pd_en(cfg_pd_en), .pd_pin(pd_pin),
      .pin_in(pin_in), .core_out(core_out), .core_oe(core_oe),
      .core_in(core_in), .core_pd_bit(core_pd_bit), .pad_out(pad_out),
      .pad_oe(pad_oe), .core_clk_en(core_clk_en), .pd_state(pd_state)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_neg(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic chk_held(input string req, input int o, input int e, input int i);
      chk(pad_out == W'(o), {req, " pad_out"}, pad_out, o);
      chk(pad_oe == W'(e), "R3 pad_oe", pad_oe, e);
      chk(core_in == W'(i), "R4 core_in", core_in, i);
      chk(core_clk_en == 1'b0, "R4 clk_en", core_clk_en, 0);
   endtask

   initial begin
      wait_neg(3);
      rst_n = 1'b1;
      wait_neg(1);
      chk(pd_state == 2'd0, "R9 reset state", pd_state, 0);
      chk(core_clk_en == 1'b1, "R4 reset clk_en", core_clk_en, 1);
      chk(EXP_WAK == 8, "R10 wake count", EXP_WAK, 8);

      // R1 / R5: feature off, block is transparent
      cfg_pd_en = 1'b0;
      for (int v = 0; v < 8; v++) begin
         core_out = W'(v); core_oe = ~W'(v); pin_in = W'(v) ^ 3'd5; pd_pin = v[0] | v[1];
         wait_neg(1);
         chk(pad_out == W'(v), "R1 pad_out", pad_out, v);
         chk(pad_oe == ~W'(v), "R1 pad_oe", pad_oe, 7 - v);
         chk(core_in == (W'(v) ^ 3'd5), "R1 core_in", core_in, v ^ 5);
         chk(core_pd_bit == pd_pin, "R5 bypass", core_pd_bit, pd_pin);
         chk(pd_state == 2'd0 && core_clk_en, "R1 stays active", pd_state, 0);
      end
      pd_pin = 1'b0;
      wait_neg(3);
      cfg_pd_en = 1'b1;
      wait_neg(1);

      // R2..R8: sweep all patterns through freeze and wake
      for (int v = 0; v < 8; v++) begin
         int vo, vi;
         vo = v ^ 3; vi = 7 - v;
         core_out = W'(v); core_oe = W'(vo); pin_in = W'(vi);
         pd_pin = 1'b1;
         wait_neg(2);
         chk(pd_state == 2'd0, "R6 still active", pd_state, 0);
         chk(core_pd_bit == 1'b0, "R5 forced low", core_pd_bit, 0);
         wait_neg(1);
         chk(pd_state == 2'd1, "R6 frozen on third edge", pd_state, 1);
         core_out = ~W'(v); core_oe = ~W'(vo); pin_in = ~W'(vi);
         wait_neg(1);
         chk_held("R2", v, vo, vi);
         pd_pin = 1'b0;
         wait_neg(3);
         chk(pd_state == 2'd2, "R7 waking", pd_state, 2);
         chk_held("R7", v, vo, vi);
         if (v == 5) begin
            pd_pin = 1'b1;
            wait_neg(3);
            chk(pd_state == 2'd1, "R8 abort to frozen", pd_state, 1);
            chk_held("R8", v, vo, vi);
            pd_pin = 1'b0;
            wait_neg(3);
            chk(pd_state == 2'd2, "R8 waking again", pd_state, 2);
         end
         wait_neg(EXP_WAK - 1);
         chk(pd_state == 2'd2, "R7 last waking cycle", pd_state, 2);
         chk_held("R7", v, vo, vi);
         wait_neg(1);
         chk(pd_state == 2'd0, "R7 released", pd_state, 0);
         chk(pad_out == ~W'(v), "R7 live pad_out", pad_out, 7 - v);
         chk(core_in == ~W'(vi), "R7 live core_in", core_in, v);
         chk(core_clk_en == 1'b1, "R7 clk_en", core_clk_en, 1);
      end
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int c = 0; c < 100000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule